// File: doc/BRIEF.md
# Packed Palette Store with Colour Expansion

This block is a colour lookup table that software fills through a word-wide bus port. Each 32-bit bus word carries two 16-bit colour entries, so 128 words describe 256 entries. The block keeps every raw word exactly as written, so the bus can read it back. In the same clock edge it unpacks both 16-bit entries of the word into 24-bit colours and stores them in a lookup memory.

Each 16-bit entry holds three 5-bit channels and one intensity bit. The intensity bit is discarded. Each channel is widened to 8 bits by placing it in the upper five bits, with the low three bits zero.

A pixel pipeline uses the lookup port. It presents an 8-bit index with a valid strobe and receives the matching 24-bit colour one cycle later. The port accepts a new index on every cycle.

Top module: `pal_convert`

## Requirements
- R1: While reset is asserted and after it is released, every raw word reads back as zero, every lookup returns colour zero, and `px_valid` is low.
- R2: `bus_rdata` shows, combinationally, all 32 bits last written to the word selected by `bus_addr`, including both intensity bits.
- R3: A write to word n loads entry 2n from bits [15:0] and entry 2n+1 from bits [31:16]. Lookup index 2n+k selects entry k of word n.
- R4: Inside an entry, the red channel is bits [4:0], green is bits [9:5] and blue is bits [14:10]. In `px_color`, red goes to [7:0], green to [15:8] and blue to [23:16]. Each channel is the 5-bit field shifted left by 3, so its low 3 bits are zero.
- R5: Bit 15 of each entry has no effect on the expanded colour.
- R6: A lookup presented with `lk_valid` high yields `px_valid` high and the colour on the next cycle. Back-to-back lookups on consecutive cycles each return their own colour.
- R7: A lookup in the cycle after a write returns the new colour for both entries of that word. A lookup in the same cycle as the write returns the previous colour.
- R8: In a cycle after one with `lk_valid` low, `px_valid` is low and `px_color` keeps its previous value.
- R9: A write changes only the two entries and the raw word of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the palette word |
| bus_addr | input | 7 | Word address, used for both write and readback |
| bus_wdata | input | 32 | Packed pair of 16-bit entries |
| bus_rdata | output | 32 | Raw word stored at `bus_addr` |
| lk_valid | input | 1 | Lookup request strobe |
| lk_index | input | 8 | Entry index to look up |
| px_valid | output | 1 | Lookup result valid, one cycle after the request |
| px_color | output | 24 | Expanded colour: blue [23:16], green [15:8], red [7:0] |

## Verification
There are three ways the internal state can go wrong, and each shows at the ports.

- A corrupted raw word shows on `bus_rdata` as soon as that address is selected, because the readback path has no register.
- A wrong derived entry, such as swapped halves, misplaced channels, a leaked intensity bit or a stray write to a neighbouring word, shows on `px_color` exactly one cycle after a lookup of that entry.
- A lost or doubled pipeline stage shows on the first back-to-back lookup pair, or on the first lookup issued right after a write. These lookups expose stale or early data within one cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int ENTRY_W  = 16;
  localparam int CH_IN_W  = 5;
  localparam int CH_OUT_W = 8;
  localparam int CH_SHIFT = CH_OUT_W - CH_IN_W;

  typedef struct packed {
    logic [CH_OUT_W-1:0] blu;
    logic [CH_OUT_W-1:0] grn;
    logic [CH_OUT_W-1:0] red;
  } rgb_t;
endpackage

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output rgb_t               color
);
  logic unused_intensity;

  assign unused_intensity = entry[ENTRY_W-1];

  always_comb begin
    color.red = {entry[0*CH_IN_W +: CH_IN_W], {CH_SHIFT{1'b0}}};
    color.grn = {entry[1*CH_IN_W +: CH_IN_W], {CH_SHIFT{1'b0}}};
    color.blu = {entry[2*CH_IN_W +: CH_IN_W], {CH_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
  parameter int NUM_WORDS = 128,
  parameter int WORD_W    = 32,
  parameter int AW        = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] raw_q [NUM_WORDS];
  logic [WORD_W-1:0] raw_d [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_en;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      word_en[w] = we && (addr == AW'(w));
      raw_d[w]   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) raw_q[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (word_en[w]) raw_q[w] <= raw_d[w];
    end
  end

  assign rdata = raw_q[addr];

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && addr == $past(addr)) |-> rdata == $past(wdata));
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_pkg::*;
#(
  parameter int NUM_WORDS = 128,
  parameter int EPW       = 2,
  parameter int WORD_AW   = $clog2(NUM_WORDS),
  parameter int SEL_W     = (EPW > 1) ? $clog2(EPW) : 1,
  parameter int IDX_W     = WORD_AW + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  rgb_t               wcolor [EPW],
  input  logic               lk_valid,
  input  logic [IDX_W-1:0]   lk_index,
  output logic               px_valid,
  output rgb_t               px_color
);
  rgb_t lut_q [NUM_WORDS][EPW];
  rgb_t px_color_d, px_color_q;
  logic px_valid_q;
  logic [WORD_AW-1:0] rd_word;
  logic [SEL_W-1:0]   rd_sel;

  assign rd_word = lk_index[IDX_W-1:SEL_W];
  assign rd_sel  = lk_index[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++)
        for (int k = 0; k < EPW; k++) lut_q[w][k] <= '0;
    end else if (we) begin
      for (int k = 0; k < EPW; k++) lut_q[waddr][k] <= wcolor[k];
    end
  end

  always_comb begin
    px_color_d = px_color_q;
    if (lk_valid) px_color_d = lut_q[rd_word][rd_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_color_q <= '0;
      px_valid_q <= 1'b0;
    end else begin
      px_color_q <= px_color_d;
      px_valid_q <= lk_valid;
    end
  end

  assign px_valid = px_valid_q;
  assign px_color = px_color_q;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> px_valid);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !px_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(px_color));
  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (px_color.red[CH_SHIFT-1:0] == '0 &&
                  px_color.grn[CH_SHIFT-1:0] == '0 &&
                  px_color.blu[CH_SHIFT-1:0] == '0));
endmodule

// File: rtl/pal_convert.sv
module pal_convert
  import pal_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 128,
  localparam int EPW      = WORD_W / ENTRY_W,
  localparam int WORD_AW  = $clog2(NUM_WORDS),
  localparam int SEL_W    = (EPW > 1) ? $clog2(EPW) : 1,
  localparam int IDX_W    = WORD_AW + SEL_W,
  localparam int COLOR_W  = 3 * CH_OUT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               lk_valid,
  input  logic [IDX_W-1:0]   lk_index,
  output logic               px_valid,
  output logic [COLOR_W-1:0] px_color
);
  rgb_t wr_color [EPW];
  rgb_t px_rgb;

  pal_raw_store #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W   (WORD_W)
  ) u_raw (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bus_we),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .rdata(bus_rdata)
  );

  for (genvar k = 0; k < EPW; k++) begin : g_exp
    pal_expand u_exp (
      .entry(bus_wdata[k*ENTRY_W +: ENTRY_W]),
      .color(wr_color[k])
    );
  end

  pal_lut #(
    .NUM_WORDS(NUM_WORDS),
    .EPW      (EPW)
  ) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .waddr   (bus_addr),
    .wcolor  (wr_color),
    .lk_valid(lk_valid),
    .lk_index(lk_index),
    .px_valid(px_valid),
    .px_color(px_rgb)
  );

  assign px_color = px_rgb;
endmodule

// File: tb/test_pal_convert.sv
`timescale 1ns/1ps
module test_pal_convert;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        lk_valid;
  logic [7:0]  lk_index;
  logic        px_valid;
  logic [23:0] px_color;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pal_convert i_pal_convert (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_valid(lk_valid),
    .lk_index(lk_index), .px_valid(px_valid), .px_color(px_color)
  );

  localparam int NV = 6;
  localparam logic [38:0] VEC [NV] = '{
    {7'd0,   32'h0000_001F},
    {7'd1,   32'h03E0_7C00},
    {7'd127, 32'hFFFF_FFFF},
    {7'd64,  32'h8000_8000},
    {7'd5,   32'h1234_ABCD},
    {7'd126, 32'h7FFF_0421}
  };

  function automatic logic [23:0] expand(input logic [15:0] e);
    return {e[14:10], 3'b000, e[9:5], 3'b000, e[4:0], 3'b000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] idx, output logic [23:0] c);
    lk_valid = 1'b1; lk_index = idx;
    @(negedge clk);
    lk_valid = 1'b0;
    c = px_color;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] c;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    lk_valid = 1'b0; lk_index = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_addr = 7'd0;   #1 chk("R1 raw0", bus_rdata, 32'h0);
    bus_addr = 7'd127; #1 chk("R1 raw127", bus_rdata, 32'h0);
    chk("R1 px_valid", {31'b0, px_valid}, 32'h0);
    @(negedge clk);
    lookup(8'd255, c); chk("R1 lut255", {8'h0, c}, 32'h0);

    // Vector table: R2, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      logic [6:0]  a;
      logic [31:0] d;
      a = VEC[i][38:32];
      d = VEC[i][31:0];
      do_write(a, d);
      bus_addr = a; #1 chk("R2 readback", bus_rdata, d);
      lookup({a, 1'b0}, c); chk("R3 R4 R5 even entry", {8'h0, c}, {8'h0, expand(d[15:0])});
      chk("R6 px_valid", {31'b0, px_valid}, 32'h1);
      lookup({a, 1'b1}, c); chk("R3 R4 R5 odd entry", {8'h0, c}, {8'h0, expand(d[31:16])});
    end

    // R5: intensity only gives black
    lookup({7'd64, 1'b1}, c); chk("R5 intensity", {8'h0, c}, 32'h0);
    // R4: channel positions
    lookup({7'd0, 1'b0}, c); chk("R4 red", {8'h0, c}, 32'h0000_00F8);
    lookup({7'd1, 1'b0}, c); chk("R4 blue", {8'h0, c}, 32'h00F8_0000);
    lookup({7'd1, 1'b1}, c); chk("R4 green", {8'h0, c}, 32'h0000_F800);
    // R9: neighbours untouched
    lookup({7'd2, 1'b0}, c); chk("R9 untouched word", {8'h0, c}, 32'h0);
    bus_addr = 7'd65; #1 chk("R9 raw untouched", bus_rdata, 32'h0);

    // R6: back-to-back lookups
    lk_valid = 1'b1; lk_index = {7'd127, 1'b0};
    @(negedge clk);
    chk("R6 pipe first", {8'h0, px_color}, {8'h0, expand(16'hFFFF)});
    lk_index = {7'd5, 1'b1};
    @(negedge clk);
    chk("R6 pipe second", {8'h0, px_color}, {8'h0, expand(16'h1234)});
    lk_valid = 1'b0; lk_index = {7'd0, 1'b0};

    // R8: hold when idle
    @(negedge clk);
    chk("R8 idle valid", {31'b0, px_valid}, 32'h0);
    chk("R8 hold colour", {8'h0, px_color}, {8'h0, expand(16'h1234)});

    // R7: same-cycle lookup sees old, next cycle sees new
    bus_we = 1'b1; bus_addr = 7'd5; bus_wdata = 32'h001F_03E0;
    lk_valid = 1'b1; lk_index = {7'd5, 1'b0};
    @(negedge clk);
    bus_we = 1'b0;
    chk("R7 same cycle old", {8'h0, px_color}, {8'h0, expand(16'hABCD)});
    lk_index = {7'd5, 1'b0};
    @(negedge clk);
    chk("R7 next even new", {8'h0, px_color}, {8'h0, expand(16'h03E0)});
    lk_index = {7'd5, 1'b1};
    @(negedge clk);
    chk("R7 next odd new", {8'h0, px_color}, {8'h0, expand(16'h001F)});
    lk_valid = 1'b0;

    // R1: mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 reset px", {8'h0, px_color}, 32'h0);
    bus_addr = 7'd127; #1 chk("R1 reset raw", bus_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lookup({7'd127, 1'b1}, c); chk("R1 reset lut", {8'h0, c}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule